// File: doc/BRIEF.md
# Alarm and Periodic Interrupt Unit

This block sits beside a real-time clock's calendar counter. It watches the current weekday, hour and minute, and it watches a set of one-cycle event pulses that the counter raises when it rolls over. From these it raises interrupts for the host. There are three interrupt sources:

- A weekday alarm. It compares a minute, an hour and a seven-day mask.
- A daily alarm. It compares a minute and an hour only.
- A periodic source. The host picks one of six rollover events for it, from half a second up to one month.

Each source has a sticky flag that the host clears with a one-cycle pulse. The shared active-low interrupt line is low while any flag is set and its source is enabled. The host can halt the periodic source's part of that line without losing its flag.

Time fields are compared for equality, so either BCD or binary encoding works, provided the alarm settings use the same encoding as the counter. Alarms are evaluated only in the cycle of a minute rollover. The counter presents the new minute's fields in that same cycle. A preset time therefore fires once, not for the whole minute it matches.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, all three flags are 0 and `irq_n` is 1.
- R2: In a cycle where `time_evt[2]` (minute rollover) is 1, the weekday flag is set after that clock edge if all three of these hold: `cur_hour` equals `wk_hour`, `cur_min` equals `wk_min`, and bit `cur_wday` of `wk_days` is 1 (bit 0 is day 0, bit 6 is day 6).
- R3: The weekday flag does not set on a minute rollover if the mask bit of the current day is 0, or if the hour or the minute differs.
- R4: The daily flag is set after a minute rollover on which `cur_hour`/`cur_min` equal `dy_hour`/`dy_min`, whatever the weekday.
- R5: Neither alarm flag sets in a cycle without a minute rollover, even when all fields match.
- R6: `time_evt` bits are 0 = half second, 1 = second, 2 = minute, 3 = hour, 4 = day, 5 = month. `per_sel` values 1 to 6 select bit `per_sel-1`. The periodic flag sets after a pulse on the selected bit and only on that bit.
- R7: `per_sel` values 0 and 7 disable the periodic source. No event sets its flag.
- R8: A set flag stays 1 until its clear input is 1. It reads 0 the cycle after the clear.
- R9: When a set and a clear of the same flag coincide, the flag is 1 after the edge.
- R10: `irq_n` is 0 exactly when (weekday flag and `wk_en`) or (daily flag and `dy_en`) or (periodic flag and not `per_halt`). Otherwise it is 1.
- R11: `per_halt` masks the periodic flag from `irq_n`. It does not stop that flag from being set by the selected event, and it does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_evt | input | 6 | Rollover pulses from the counter (half s, s, min, hour, day, month) |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| cur_hour | input | 8 | Current hour field |
| cur_min | input | 8 | Current minute field |
| wk_days | input | 7 | Weekday alarm day mask |
| wk_hour | input | 8 | Weekday alarm hour |
| wk_min | input | 8 | Weekday alarm minute |
| wk_en | input | 1 | Weekday alarm drives irq_n |
| dy_hour | input | 8 | Daily alarm hour |
| dy_min | input | 8 | Daily alarm minute |
| dy_en | input | 1 | Daily alarm drives irq_n |
| per_sel | input | 3 | Periodic event select |
| per_halt | input | 1 | Masks periodic flag from irq_n |
| wk_clr | input | 1 | Clear weekday flag |
| dy_clr | input | 1 | Clear daily flag |
| per_clr | input | 1 | Clear periodic flag |
| wk_flag | output | 1 | Weekday alarm flag |
| dy_flag | output | 1 | Daily alarm flag |
| per_flag | output | 1 | Periodic flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The alarms are tried with several patterns:

- A full match on a minute rollover.
- The same match with the current day's mask bit clear.
- A mismatched hour.
- Matching fields pulsed on a non-minute event. This separates gating by the minute rollover from a plain level comparison.
- The daily alarm on two different weekdays. This shows that its result does not depend on the weekday.

Every `per_sel` value is crossed with a pulse on every event bit. This reveals a wrong index or an off-by-one in the selection, and shows that the values 0 and 7 stay silent. A clear that coincides with a set, together with each enable and the halt toggled while a flag is held, separates flag state from output masking.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_EVT  = 6;
  localparam int NUM_DAYS = 7;
  localparam int WDAY_W   = $clog2(NUM_DAYS);
  localparam int SEL_W    = 3;
  localparam int EVT_MIN  = 2;
  localparam int NUM_SRC  = 3;

  typedef enum logic [SEL_W-1:0] {
    PSEL_NONE  = 3'd0,
    PSEL_HALF  = 3'd1,
    PSEL_SEC   = 3'd2,
    PSEL_MIN   = 3'd3,
    PSEL_HOUR  = 3'd4,
    PSEL_DAY   = 3'd5,
    PSEL_MONTH = 3'd6,
    PSEL_SPARE = 3'd7
  } psel_e;

  // Selected rollover event: values 1..NUM_EVT pick bit (sel-1).
  function automatic logic period_hit(input logic [SEL_W-1:0] sel,
                                      input logic [NUM_EVT-1:0] evt);
    logic [SEL_W-1:0] idx;
    idx = sel - 3'd1;
    if (sel == PSEL_NONE || int'(sel) > NUM_EVT) return 1'b0;
    return evt[idx];
  endfunction

  // Day mask lookup; out-of-range weekday never matches.
  function automatic logic day_selected(input logic [NUM_DAYS-1:0] mask,
                                        input logic [WDAY_W-1:0] wday);
    if (int'(wday) >= NUM_DAYS) return 1'b0;
    return mask[wday];
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter int FIELD_W  = 8,
  parameter bit USE_WDAY = 1'b1
) (
  input  logic                minute_evt,
  input  logic [WDAY_W-1:0]   cur_wday,
  input  logic [FIELD_W-1:0]  cur_hour,
  input  logic [FIELD_W-1:0]  cur_min,
  input  logic [NUM_DAYS-1:0] set_days,
  input  logic [FIELD_W-1:0]  set_hour,
  input  logic [FIELD_W-1:0]  set_min,
  output logic                hit
);
  logic time_eq;
  logic day_ok;

  assign time_eq = (cur_hour == set_hour) && (cur_min == set_min);

  generate
    if (USE_WDAY) begin : g_wday
      assign day_ok = day_selected(set_days, cur_wday);
    end else begin : g_any_day
      logic unused_days;
      assign unused_days = ^{set_days, cur_wday};
      assign day_ok = 1'b1;
    end
  endgenerate

  assign hit = minute_evt && time_eq && day_ok;
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  time_evt,
  input  logic [WDAY_W-1:0]   cur_wday,
  input  logic [FIELD_W-1:0]  cur_hour,
  input  logic [FIELD_W-1:0]  cur_min,
  input  logic [NUM_DAYS-1:0] wk_days,
  input  logic [FIELD_W-1:0]  wk_hour,
  input  logic [FIELD_W-1:0]  wk_min,
  input  logic                wk_en,
  input  logic [FIELD_W-1:0]  dy_hour,
  input  logic [FIELD_W-1:0]  dy_min,
  input  logic                dy_en,
  input  logic [SEL_W-1:0]    per_sel,
  input  logic                per_halt,
  input  logic                wk_clr,
  input  logic                dy_clr,
  input  logic                per_clr,
  output logic                wk_flag,
  output logic                dy_flag,
  output logic                per_flag,
  output logic                irq_n
);
  // Named events for the checker.
  logic wk_hit, dy_hit, per_hit;
  logic [NUM_SRC-1:0] src_set, src_clr, src_flag, src_en;

  rtc_alarm_cmp #(.FIELD_W(FIELD_W), .USE_WDAY(1'b1)) u_wk_cmp (
    .minute_evt(time_evt[EVT_MIN]), .cur_wday(cur_wday),
    .cur_hour(cur_hour), .cur_min(cur_min),
    .set_days(wk_days), .set_hour(wk_hour), .set_min(wk_min),
    .hit(wk_hit)
  );

  rtc_alarm_cmp #(.FIELD_W(FIELD_W), .USE_WDAY(1'b0)) u_dy_cmp (
    .minute_evt(time_evt[EVT_MIN]), .cur_wday(cur_wday),
    .cur_hour(cur_hour), .cur_min(cur_min),
    .set_days({NUM_DAYS{1'b1}}), .set_hour(dy_hour), .set_min(dy_min),
    .hit(dy_hit)
  );

  assign per_hit = period_hit(per_sel, time_evt);

  assign src_set = {per_hit, dy_hit, wk_hit};
  assign src_clr = {per_clr, dy_clr, wk_clr};
  assign src_en  = {~per_halt, dy_en, wk_en};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
      rtc_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .set_i(src_set[s]), .clr_i(src_clr[s]),
        .flag_o(src_flag[s])
      );
    end
  endgenerate

  assign wk_flag  = src_flag[0];
  assign dy_flag  = src_flag[1];
  assign per_flag = src_flag[2];
  assign irq_n    = ~|(src_flag & src_en);
endmodule

// File: rtl/rtc_alarm_irq_checker.sv
module rtc_alarm_irq_checker
  import rtc_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] time_evt,
  input logic [SEL_W-1:0]   per_sel,
  input logic               wk_en,
  input logic               per_halt,
  input logic               wk_clr,
  input logic               per_clr,
  input logic               wk_hit,
  input logic               dy_hit,
  input logic               per_hit,
  input logic               wk_flag,
  input logic               dy_flag,
  input logic               per_flag,
  input logic               irq_n
);
  a_r2_wk_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wk_hit |=> wk_flag);
  a_r4_dy_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dy_hit |=> dy_flag);
  a_r5_alarm_needs_minute: assert property (@(posedge clk) disable iff (!rst_n)
    !time_evt[EVT_MIN] |-> (!wk_hit && !dy_hit));
  a_r7_sel_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_sel == 3'd0 || per_sel == 3'd7) && !per_flag) |=> !per_flag);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_flag && !wk_clr) |=> wk_flag);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && per_clr) |=> per_flag);
  a_r10_wk_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_flag && wk_en) |-> !irq_n);
  a_r11_halt_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (per_halt && !wk_flag && !dy_flag) |-> irq_n);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_checker u_checker (
  .clk(clk), .rst_n(rst_n), .time_evt(time_evt), .per_sel(per_sel),
  .wk_en(wk_en), .per_halt(per_halt), .wk_clr(wk_clr), .per_clr(per_clr),
  .wk_hit(wk_hit), .dy_hit(dy_hit), .per_hit(per_hit),
  .wk_flag(wk_flag), .dy_flag(dy_flag), .per_flag(per_flag), .irq_n(irq_n)
);

// File: tb/rtc_alarm_irq_bench.sv
`timescale 1ns/1ps
module rtc_alarm_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] time_evt = '0;
  logic [2:0] cur_wday = '0;
  logic [7:0] cur_hour = '0, cur_min = '0;
  logic [6:0] wk_days = '0;
  logic [7:0] wk_hour = '0, wk_min = '0, dy_hour = '0, dy_min = '0;
  logic       wk_en = 1'b0, dy_en = 1'b0, per_halt = 1'b0;
  logic [2:0] per_sel = '0;
  logic       wk_clr = 1'b0, dy_clr = 1'b0, per_clr = 1'b0;
  logic       wk_flag, dy_flag, per_flag, irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .time_evt(time_evt), .cur_wday(cur_wday),
    .cur_hour(cur_hour), .cur_min(cur_min), .wk_days(wk_days),
    .wk_hour(wk_hour), .wk_min(wk_min), .wk_en(wk_en),
    .dy_hour(dy_hour), .dy_min(dy_min), .dy_en(dy_en),
    .per_sel(per_sel), .per_halt(per_halt),
    .wk_clr(wk_clr), .dy_clr(dy_clr), .per_clr(per_clr),
    .wk_flag(wk_flag), .dy_flag(dy_flag), .per_flag(per_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle of events/clears at a falling edge; results are
  // observable at the next falling edge (one register stage).
  task automatic pulse(input logic [5:0] evt, input logic [2:0] clr);
    @(negedge clk);
    time_evt = evt; {per_clr, dy_clr, wk_clr} = clr;
    @(negedge clk);
    time_evt = '0; {per_clr, dy_clr, wk_clr} = '0;
  endtask

  task automatic clear_all();
    pulse(6'b0, 3'b111);
  endtask

  task automatic t_reset();
    check("R1 wk_flag", wk_flag, 1'b0);
    check("R1 dy_flag", dy_flag, 1'b0);
    check("R1 per_flag", per_flag, 1'b0);
    check("R1 irq_n", irq_n, 1'b1);
  endtask

  task automatic t_weekday();
    wk_hour = 8'h07; wk_min = 8'h30; wk_days = 7'b0000100; wk_en = 1'b1;
    dy_hour = 8'h22; dy_min = 8'h15; dy_en = 1'b1;
    cur_wday = 3'd2; cur_hour = 8'h07; cur_min = 8'h30;
    pulse(6'b000100, 3'b000);
    check("R2 weekday match", wk_flag, 1'b1);
    check("R4 daily off-time", dy_flag, 1'b0);
    check("R10 irq from weekday", irq_n, 1'b0);
    clear_all();
    check("R8 clear drops", wk_flag, 1'b0);
    check("R10 irq idle", irq_n, 1'b1);
    cur_wday = 3'd3;
    pulse(6'b000100, 3'b000);
    check("R3 day bit clear", wk_flag, 1'b0);
    cur_wday = 3'd2; cur_hour = 8'h08;
    pulse(6'b000100, 3'b000);
    check("R3 hour differs", wk_flag, 1'b0);
  endtask

  task automatic t_daily();
    dy_hour = 8'h07; dy_min = 8'h30;
    cur_hour = 8'h07; cur_min = 8'h30;
    foreach (cur_wday[i]) ;
    cur_wday = 3'd5;
    pulse(6'b000100, 3'b000);
    check("R4 daily day5", dy_flag, 1'b1);
    clear_all();
    cur_wday = 3'd0;
    pulse(6'b000100, 3'b000);
    check("R4 daily day0", dy_flag, 1'b1);
    clear_all();
  endtask

  task automatic t_no_minute();
    cur_wday = 3'd2; cur_hour = 8'h07; cur_min = 8'h30;
    pulse(6'b111011, 3'b000);
    check("R5 weekday needs minute", wk_flag, 1'b0);
    check("R5 daily needs minute", dy_flag, 1'b0);
  endtask

  task automatic t_period();
    cur_min = 8'h59;
    for (int s = 0; s < 8; s++) begin
      per_sel = 3'(s);
      for (int b = 0; b < 6; b++) begin
        pulse(6'(1 << b), 3'b000);
        if (s == 0 || s == 7)
          check("R7 select off", per_flag, 1'b0);
        else
          check("R6 period select", per_flag, (b == s - 1));
        clear_all();
      end
    end
  endtask

  task automatic t_sticky_collide();
    per_sel = 3'd2;
    pulse(6'b000010, 3'b000);
    repeat (5) @(negedge clk);
    check("R8 sticky", per_flag, 1'b1);
    clear_all();
    pulse(6'b000010, 3'b100);
    check("R9 set beats clear", per_flag, 1'b1);
    clear_all();
  endtask

  task automatic t_enables();
    cur_wday = 3'd2; cur_hour = 8'h07; cur_min = 8'h30;
    wk_en = 1'b0; dy_en = 1'b0;
    pulse(6'b000100, 3'b000);
    check("R10 flags held", wk_flag & dy_flag, 1'b1);
    check("R10 disabled alarms", irq_n, 1'b1);
    dy_en = 1'b1; #0.1;
    check("R10 daily enable", irq_n, 1'b0);
    clear_all();
    dy_en = 1'b0; per_halt = 1'b1; per_sel = 3'd1;
    pulse(6'b000001, 3'b000);
    check("R11 halted still sets", per_flag, 1'b1);
    check("R11 halted masked", irq_n, 1'b1);
    per_halt = 1'b0; #0.1;
    check("R11 release drives", irq_n, 1'b0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_weekday();
    t_daily();
    t_no_minute();
    t_period();
    t_sticky_collide();
    t_enables();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule